// File: doc/BRIEF.md
# Latency Tolerance Policy Engine

This block sits beside the transaction layer of a PCIe endpoint. It chooses the memory access latency the device can currently tolerate and asks the link layer to send a tolerance report message each time that choice changes. In hardware-driven mode, the value follows the device's own state. Traffic or an urgent burst selects the active tier. A programmable run of microsecond ticks without traffic drops back to the active-idle tier. Power-state hints override both tiers. In software-guided mode, the reported value changes only when software writes the trigger register, and the written value is used.

Values are kept in microseconds inside the block. They are turned into the wire code only where the report is formed. A single pending slot holds the next report. The slot is refreshed in place while it waits, and it is withheld while reporting is disabled or while the code equals the one last sent. After a lowered value is accepted, a countdown keeps the new value from being treated as in force until the previously reported, larger latency has elapsed.

Top module: `lat_tol_engine`

## Requirements
- R1: After reset no report is pending (`msg_valid` low), the tier is active-idle, `lat_settled` is high, and the last-sent code equals the default active-idle code.
- R2: The report code is 16 bits. Bit 15 is the requirement flag. Bits 14:13 are zero. Bits 12:10 hold the scale s, with a unit of 32^s ns. Bits 9:0 hold floor(ns / 32^s), where s is the smallest scale that keeps this value below 1024. "No requirement" is the code 0x0000. Examples: 60 us is 0x883A and 400 us is 0x8986.
- R3: Traffic or an urgent burst selects the active tier at once. After `idle_tmo_us` ticks of `us_tick` with neither present, counted from the last cycle with traffic, the tier returns to active-idle.
- R4: A programmed value of zero selects the default: 60 us active, 400 us active-idle, 1000 us maximum platform latency. The active-idle value is raised to at least 300 us.
- R5: While not associated, the target is "no requirement". While associated with the radio off, or in low power idle, the target is the maximum platform latency. These overrides take precedence over the tiers.
- R6: While `urgent` is high in the associated, radio-on, non-idle state, the target is the smaller of `urg_lat_us` and the active value. When `urgent` falls, the target goes back to the active value.
- R7: With `sw_mode` high, the target changes only on a `sw_wr` pulse, and it becomes `sw_lat_us` with the requirement flag set. Hardware state changes produce no report.
- R8: A report is requested only when the target code differs from the last code accepted. No report is requested while `en` is low, and a change made while disabled is reported once `en` returns.
- R9: A target change while a report is pending replaces the pending code without a second report. If the target returns to the last-sent code, the pending report is withdrawn.
- R10: Accepting a lower value clears `lat_settled`. It rises again only after as many `us_tick` pulses as the previously reported value in microseconds. If the previous report was "no requirement", the maximum platform latency is used instead. Accepting a higher value leaves `lat_settled` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| en | input | 1 | Reporting enable |
| sw_mode | input | 1 | 1 = software-guided, 0 = hardware-driven |
| traffic | input | 1 | Device activity indication |
| urgent | input | 1 | Short demanding burst in progress |
| assoc | input | 1 | Device associated with its network |
| radio_off | input | 1 | Radio switched off |
| lp_idle | input | 1 | Link partner in low power idle |
| act_lat_us | input | LAT_W | Active tier value in us (0 = default) |
| aidle_lat_us | input | LAT_W | Active-idle tier value in us (0 = default) |
| max_plat_us | input | LAT_W | Maximum platform latency in us (0 = default) |
| urg_lat_us | input | LAT_W | Burst tolerance in us |
| idle_tmo_us | input | TMO_W | Ticks without traffic before active-idle |
| sw_wr | input | 1 | Software trigger write strobe |
| sw_lat_us | input | LAT_W | Value written with the trigger, in us |
| msg_ready | input | 1 | Link layer accepts the pending report |
| msg_valid | output | 1 | Report pending |
| msg_code | output | 16 | Encoded tolerance of the pending report |
| lat_settled | output | 1 | The last accepted value is in force |

## Verification
The assertions assume that `us_tick` never falls on the same edge as a lowering acceptance. They also assume that reset is not reasserted in the middle of a software-mode window, and that the sequence of accepted codes seen at the ports is the sequence the block itself compares against. The stimulus meets these conditions. It changes inputs only on falling edges and keeps ticks apart from handshake cycles. It raises `msg_ready` for exactly one cycle after `msg_valid` is seen. Random settings of programmed values and power states are applied one at a time, and each is allowed to settle before the result is checked.

// File: rtl/lat_tol_pkg.sv
package lat_tol_pkg;

   localparam int CODE_W  = 16;
   localparam int MANT_W  = 10;
   localparam int SCALE_W = 3;
   localparam int NS_W    = 48;
   localparam int STEP    = 5;   // each scale step multiplies the unit by 32

   typedef enum logic {TIER_ACT = 1'b0, TIER_AIDLE = 1'b1} tier_e;

   typedef struct packed {
      logic        req;
      logic [31:0] us;
   } lat_val_t;

   // Convert a microsecond value into the 16-bit wire code
   function automatic logic [CODE_W-1:0] lt_encode(input lat_val_t v);
      logic [NS_W-1:0]    ns;
      logic [NS_W-1:0]    sh;
      logic [SCALE_W-1:0] sel;
      logic [CODE_W-1:0]  code;
      ns  = NS_W'(v.us) * NS_W'(1000);
      sel = '1;
      for (int s = 7; s >= 0; s--) begin
         sh = ns >> (STEP * s);
         if (sh < NS_W'(1 << MANT_W)) sel = SCALE_W'(s);
      end
      sh   = ns >> (STEP * int'(sel));
      code = '0;
      if (v.req) begin
         code[CODE_W-1]                  = 1'b1;
         code[MANT_W+SCALE_W-1:MANT_W]   = sel;
         code[MANT_W-1:0]                = sh[MANT_W-1:0];
      end
      return code;
   endfunction

endpackage

// File: rtl/lat_tol_tier.sv
module lat_tol_tier
   import lat_tol_pkg::*;
#(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             us_tick,
   input  logic             busy,
   input  logic [TMO_W-1:0] tmo,
   output tier_e            tier
);

   logic [TMO_W-1:0] cnt_q;
   tier_e            tier_q;
   logic             expire;

   assign expire = ({1'b0, cnt_q} + (TMO_W+1)'(1)) >= {1'b0, tmo};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tier_q <= TIER_AIDLE;
         cnt_q  <= '0;
      end else if (busy) begin
         tier_q <= TIER_ACT;
         cnt_q  <= '0;
      end else if (us_tick && tier_q == TIER_ACT) begin
         if (expire) begin
            tier_q <= TIER_AIDLE;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign tier = tier_q;

endmodule

// File: rtl/lat_tol_slot.sv
module lat_tol_slot
   import lat_tol_pkg::*;
#(
   parameter lat_val_t            RST_VAL  = '{req: 1'b1, us: 32'd400},
   parameter logic [CODE_W-1:0]   RST_CODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  lat_val_t          tgt,
   input  logic              msg_ready,
   output logic              msg_valid,
   output logic [CODE_W-1:0] msg_code,
   output logic              acc,
   output lat_val_t          acc_val,
   output lat_val_t          prev_val
);

   logic [CODE_W-1:0] tgt_code;
   logic [CODE_W-1:0] last_code_nx;
   logic              pend_q;
   logic [CODE_W-1:0] pend_code_q;
   lat_val_t          pend_val_q;
   logic [CODE_W-1:0] last_code_q;
   lat_val_t          last_val_q;

   assign tgt_code     = lt_encode(tgt);
   assign acc          = pend_q && msg_ready;
   assign last_code_nx = acc ? pend_code_q : last_code_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_code_q <= RST_CODE;
         pend_val_q  <= RST_VAL;
         last_code_q <= RST_CODE;
         last_val_q  <= RST_VAL;
      end else begin
         // one slot: refreshed in place, withdrawn when nothing new remains
         pend_q      <= en && (tgt_code != last_code_nx);
         pend_code_q <= tgt_code;
         pend_val_q  <= tgt;
         if (acc) begin
            last_code_q <= pend_code_q;
            last_val_q  <= pend_val_q;
         end
      end
   end

   assign msg_valid = pend_q;
   assign msg_code  = pend_code_q;
   assign acc_val   = pend_val_q;
   assign prev_val  = last_val_q;

endmodule

// File: rtl/lat_tol_guard.sv
module lat_tol_guard
   import lat_tol_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        us_tick,
   input  logic        acc,
   input  lat_val_t    new_val,
   input  lat_val_t    prev_val,
   input  logic [31:0] ceil_us,
   output logic        settled
);

   logic [31:0] cnt_q;
   logic [31:0] dec;
   logic [31:0] load;
   logic        lowering;

   assign lowering = acc && new_val.req &&
                     (!prev_val.req || (new_val.us < prev_val.us));
   assign load     = prev_val.req ? prev_val.us : ceil_us;
   assign dec      = (us_tick && cnt_q != '0) ? cnt_q - 32'd1 : cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (lowering) cnt_q <= (load > dec) ? load : dec;
      else               cnt_q <= dec;
   end

   assign settled = (cnt_q == '0);

endmodule

// File: rtl/lat_tol_engine.sv
module lat_tol_engine
   import lat_tol_pkg::*;
#(
   parameter int LAT_W          = 20,
   parameter int TMO_W          = 16,
   parameter int DEF_ACT_US     = 60,
   parameter int DEF_AIDLE_US   = 400,
   parameter int AIDLE_FLOOR_US = 300,
   parameter int DEF_MAXPLAT_US = 1000,
   parameter bit GUARD_EN       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              us_tick,
   input  logic              en,
   input  logic              sw_mode,
   input  logic              traffic,
   input  logic              urgent,
   input  logic              assoc,
   input  logic              radio_off,
   input  logic              lp_idle,
   input  logic [LAT_W-1:0]  act_lat_us,
   input  logic [LAT_W-1:0]  aidle_lat_us,
   input  logic [LAT_W-1:0]  max_plat_us,
   input  logic [LAT_W-1:0]  urg_lat_us,
   input  logic [TMO_W-1:0]  idle_tmo_us,
   input  logic              sw_wr,
   input  logic [LAT_W-1:0]  sw_lat_us,
   input  logic              msg_ready,
   output logic              msg_valid,
   output logic [15:0]       msg_code,
   output logic              lat_settled
);

   localparam lat_val_t          RST_VAL  = '{req: 1'b1, us: 32'(DEF_AIDLE_US)};
   localparam logic [CODE_W-1:0] RST_CODE = lt_encode(RST_VAL);

   if (LAT_W < 1 || LAT_W > 32) begin : g_bad_lat_w
      $error("LAT_W must lie in 1..32");
   end
   if (TMO_W < 1) begin : g_bad_tmo_w
      $error("TMO_W must be positive");
   end
   if (DEF_AIDLE_US < AIDLE_FLOOR_US) begin : g_bad_aidle
      $error("default active-idle value lies below its floor");
   end
   if (DEF_ACT_US < 1 || DEF_MAXPLAT_US < 1) begin : g_bad_defaults
      $error("default tier values must be nonzero");
   end

   logic [31:0] act_us;
   logic [31:0] aidle_us;
   logic [31:0] maxp_us;
   logic [31:0] urg_us;
   tier_e       tier;
   lat_val_t    hw_tgt;
   lat_val_t    tgt_q;
   logic        acc;
   lat_val_t    acc_val;
   lat_val_t    prev_val;

   // programmed values with defaults and floor applied
   always_comb begin
      act_us   = (act_lat_us   == '0) ? 32'(DEF_ACT_US)     : 32'(act_lat_us);
      aidle_us = (aidle_lat_us == '0) ? 32'(DEF_AIDLE_US)   : 32'(aidle_lat_us);
      maxp_us  = (max_plat_us  == '0) ? 32'(DEF_MAXPLAT_US) : 32'(max_plat_us);
      if (aidle_us < 32'(AIDLE_FLOOR_US)) aidle_us = 32'(AIDLE_FLOOR_US);
      urg_us   = 32'(urg_lat_us);
      if (urg_us > act_us) urg_us = act_us;
   end

   lat_tol_tier #(.TMO_W(TMO_W)) u_tier (
      .clk     (clk),
      .rst_n   (rst_n),
      .us_tick (us_tick),
      .busy    (traffic || urgent),
      .tmo     (idle_tmo_us),
      .tier    (tier)
   );

   // hardware policy: overrides first, then burst, then tier
   always_comb begin
      hw_tgt.req = 1'b1;
      hw_tgt.us  = aidle_us;
      if (!assoc) begin
         hw_tgt.req = 1'b0;
         hw_tgt.us  = '0;
      end else if (radio_off || lp_idle) begin
         hw_tgt.us = maxp_us;
      end else if (urgent) begin
         hw_tgt.us = urg_us;
      end else if (tier == TIER_ACT) begin
         hw_tgt.us = act_us;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       tgt_q <= RST_VAL;
      else if (!sw_mode) tgt_q <= hw_tgt;
      else if (sw_wr)   tgt_q <= '{req: 1'b1, us: 32'(sw_lat_us)};
   end

   lat_tol_slot #(.RST_VAL(RST_VAL), .RST_CODE(RST_CODE)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .tgt       (tgt_q),
      .msg_ready (msg_ready),
      .msg_valid (msg_valid),
      .msg_code  (msg_code),
      .acc       (acc),
      .acc_val   (acc_val),
      .prev_val  (prev_val)
   );

   if (GUARD_EN) begin : g_guard
      lat_tol_guard u_guard (
         .clk      (clk),
         .rst_n    (rst_n),
         .us_tick  (us_tick),
         .acc      (acc),
         .new_val  (acc_val),
         .prev_val (prev_val),
         .ceil_us  (maxp_us),
         .settled  (lat_settled)
      );
   end else begin : g_no_guard
      assign lat_settled = 1'b1;
   end

endmodule

// File: rtl/lat_tol_chk.sv
module lat_tol_chk #(
   parameter logic [15:0] RST_CODE = 16'h0,
   parameter bit          GUARD_EN = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        en,
   input logic        sw_mode,
   input logic        sw_wr,
   input logic        us_tick,
   input logic        msg_valid,
   input logic        msg_ready,
   input logic [15:0] msg_code,
   input logic        lat_settled
);

   logic [15:0] seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                      seen_q <= RST_CODE;
      else if (msg_valid && msg_ready) seen_q <= msg_code;
   end

   AST_OFF_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !msg_valid);  // R8

   AST_NO_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (msg_code != seen_q));  // R8

   AST_NOREQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_code[15]) |-> (msg_code[14:0] == 15'h0));  // R2

   AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sw_mode, 2) && !$past(sw_wr, 2)) |-> $stable(msg_code));  // R7

   if (GUARD_EN) begin : g_guard_props
      AST_LOWER_UNSETTLES: assert property (@(posedge clk) disable iff (!rst_n)
         (msg_valid && msg_ready && msg_code[15] &&
          (!seen_q[15] || msg_code[12:0] < seen_q[12:0])) |=> !lat_settled);  // R10

      AST_SETTLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(lat_settled) |-> $past(us_tick));  // R10
   end

endmodule

bind lat_tol_engine lat_tol_chk #(.RST_CODE(RST_CODE), .GUARD_EN(GUARD_EN)) u_lat_tol_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .sw_mode     (sw_mode),
   .sw_wr       (sw_wr),
   .us_tick     (us_tick),
   .msg_valid   (msg_valid),
   .msg_ready   (msg_ready),
   .msg_code    (msg_code),
   .lat_settled (lat_settled)
);

// File: tb/lat_tol_engine_tb.sv
`timescale 1ns/1ps
module lat_tol_engine_tb;

   localparam int LAT_W = 20;
   localparam int TMO_W = 16;
   localparam int TMO   = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             us_tick = 1'b0, en = 1'b0, sw_mode = 1'b0, traffic = 1'b0;
   logic             urgent = 1'b0, assoc = 1'b0, radio_off = 1'b0, lp_idle = 1'b0;
   logic [LAT_W-1:0] act_lat_us = '0, aidle_lat_us = '0, max_plat_us = '0;
   logic [LAT_W-1:0] urg_lat_us = '0, sw_lat_us = '0;
   logic [TMO_W-1:0] idle_tmo_us = '0;
   logic             sw_wr = 1'b0, msg_ready = 1'b0;
   logic             msg_valid, lat_settled;
   logic [15:0]      msg_code;

   int          n_chk = 0;
   int          n_fail = 0;
   logic [15:0] last_exp = 16'h8986;
   bit          b_act = 1'b0;

   always #2.5 clk = ~clk;

   lat_tol_engine #(.LAT_W(LAT_W), .TMO_W(TMO_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .en(en), .sw_mode(sw_mode),
      .traffic(traffic), .urgent(urgent), .assoc(assoc), .radio_off(radio_off),
      .lp_idle(lp_idle), .act_lat_us(act_lat_us), .aidle_lat_us(aidle_lat_us),
      .max_plat_us(max_plat_us), .urg_lat_us(urg_lat_us), .idle_tmo_us(idle_tmo_us),
      .sw_wr(sw_wr), .sw_lat_us(sw_lat_us), .msg_ready(msg_ready),
      .msg_valid(msg_valid), .msg_code(msg_code), .lat_settled(lat_settled)
   );

   function automatic logic [15:0] enc(input bit req, input longint us);
      longint ns;
      int     s;
      if (!req) return 16'h0000;
      ns = us * 1000;
      s  = 0;
      while (ns >= 1024) begin
         ns = ns >>> 5;
         s++;
      end
      return {1'b1, 2'b00, 3'(s), 10'(ns)};
   endfunction

   // expected target from the requirements
   function automatic logic [15:0] model();
      longint a, v;
      if (!assoc) return enc(1'b0, 0);
      if (radio_off || lp_idle) return enc(1'b1, (max_plat_us == 0) ? 1000 : longint'(max_plat_us));
      a = (act_lat_us == 0) ? 60 : longint'(act_lat_us);
      if (b_act) return enc(1'b1, a);
      v = (aidle_lat_us == 0) ? 400 : longint'(aidle_lat_us);
      if (v < 300) v = 300;
      return enc(1'b1, v);
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick();
      us_tick = 1'b1;
      @(negedge clk);
      us_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic wait_valid();
      for (int w = 0; w < 20 && !msg_valid; w++) @(negedge clk);
   endtask

   task automatic expect_msg(input logic [15:0] exp, input string tag);
      wait_valid();
      chk(msg_valid && msg_code == exp, tag, {msg_valid, msg_code}, {1'b1, exp});
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
      last_exp = exp;
   endtask

   task automatic expect_none(input string tag);
      cyc(6);
      chk(!msg_valid, tag, {msg_valid, msg_code}, 0);
   endtask

   initial begin
      #1000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [15:0] e;
      void'($urandom(32'd1977));
      cyc(4);
      rst_n = 1'b1;
      cyc(2);
      chk(!msg_valid && lat_settled, "R1 reset state", {msg_valid, lat_settled}, 1);

      idle_tmo_us = TMO_W'(TMO);
      urg_lat_us  = 20;
      assoc       = 1'b1;
      en          = 1'b1;
      expect_none("R1 R4 default active-idle matches reset code");

      // burst then idle, with lowering pacing
      traffic = 1'b1;
      b_act   = 1'b1;
      expect_msg(16'h883A, "R3 R2 active tier 60us");
      chk(!lat_settled, "R10 lowering clears settled", lat_settled, 0);
      repeat (399) tick();
      chk(!lat_settled, "R10 still held after 399 ticks", lat_settled, 0);
      tick();
      chk(lat_settled, "R10 settled after 400 ticks", lat_settled, 1);
      traffic = 1'b0;
      repeat (TMO - 1) tick();
      expect_none("R3 no change before timeout");
      tick();
      b_act = 1'b0;
      expect_msg(16'h8986, "R3 R2 active-idle after timeout");
      chk(lat_settled, "R10 raise keeps settled", lat_settled, 1);

      // floor and defaults
      aidle_lat_us = 100;
      expect_msg(enc(1, 300), "R4 floor 300us");
      aidle_lat_us = 700;
      expect_msg(enc(1, 700), "R4 programmed active-idle");
      aidle_lat_us = 0;
      expect_msg(enc(1, 400), "R4 default active-idle");

      // power-state overrides
      assoc = 1'b0;
      expect_msg(16'h0000, "R5 unassociated no requirement");
      assoc = 1'b1;
      radio_off = 1'b1;
      expect_msg(enc(1, 1000), "R5 radio off default max");
      chk(!lat_settled, "R10 lowering from no requirement", lat_settled, 0);
      max_plat_us = 2000;
      expect_msg(enc(1, 2000), "R5 programmed max");
      radio_off = 1'b0;
      lp_idle = 1'b1;
      expect_none("R5 R8 low power idle same value");
      lp_idle = 1'b0;
      expect_msg(enc(1, 400), "R5 override released");

      // burst below active
      traffic = 1'b1;
      @(negedge clk);
      traffic = 1'b0;
      b_act = 1'b1;
      expect_msg(enc(1, 60), "R3 traffic pulse");
      urgent = 1'b1;
      expect_msg(enc(1, 20), "R6 urgent lowers");
      urgent = 1'b0;
      expect_msg(enc(1, 60), "R6 back to active");
      urg_lat_us = 150;
      urgent = 1'b1;
      expect_none("R6 urgent above active clamps");
      urgent = 1'b0;

      // enable gating
      en = 1'b0;
      act_lat_us = 80;
      expect_none("R8 disabled no report");
      en = 1'b1;
      expect_msg(enc(1, 80), "R8 reported after enable");
      act_lat_us = 0;
      expect_msg(enc(1, 60), "R4 default active");

      // replacement of a pending report
      act_lat_us = 90;
      wait_valid();
      chk(msg_valid && msg_code == enc(1, 90), "R9 pending first", msg_code, enc(1, 90));
      act_lat_us = 70;
      cyc(3);
      chk(msg_valid && msg_code == enc(1, 70), "R9 replaced in place", msg_code, enc(1, 70));
      expect_msg(enc(1, 70), "R9 replaced accepted");
      expect_none("R9 single report");
      act_lat_us = 90;
      wait_valid();
      act_lat_us = 70;
      cyc(4);
      chk(!msg_valid, "R9 withdrawn on return to sent", msg_valid, 0);
      act_lat_us = 0;
      expect_msg(enc(1, 60), "R9 new value later");

      // constrained random in hardware mode
      for (int i = 0; i < 24; i++) begin
         int st;
         act_lat_us   = LAT_W'($urandom_range(200, 1));
         aidle_lat_us = LAT_W'($urandom_range(900, 0));
         max_plat_us  = LAT_W'($urandom_range(3000, 0));
         st = int'($urandom_range(4, 0));
         assoc     = (st != 0);
         radio_off = (st == 1);
         lp_idle   = (st == 2);
         if (st == 3) begin
            traffic = 1'b1;
            @(negedge clk);
            traffic = 1'b0;
            b_act = 1'b1;
         end else if (st == 4) begin
            repeat (TMO) tick();
            b_act = 1'b0;
         end
         cyc(2);
         e = model();
         if (e != last_exp) expect_msg(e, "R3 R5 random state");
         else expect_none("R8 R5 random unchanged");
      end

      // software-guided mode
      assoc = 1'b1;
      radio_off = 1'b0;
      lp_idle = 1'b0;
      sw_mode = 1'b1;
      cyc(2);
      act_lat_us = 33;
      traffic = 1'b1;
      @(negedge clk);
      traffic = 1'b0;
      repeat (TMO) tick();
      expect_none("R7 hardware ignored in software mode");
      sw_lat_us = 250;
      sw_wr = 1'b1;
      @(negedge clk);
      sw_wr = 1'b0;
      if (enc(1, 250) != last_exp) expect_msg(enc(1, 250), "R7 written value");
      sw_wr = 1'b1;
      @(negedge clk);
      sw_wr = 1'b0;
      expect_none("R7 R8 same write no report");
      sw_lat_us = 5000;
      sw_wr = 1'b1;
      @(negedge clk);
      sw_wr = 1'b0;
      expect_msg(enc(1, 5000), "R7 second write");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule